// File: doc/BRIEF.md
# Calendar Counter with Update Cycle

This block is the timekeeping core of a real-time clock. It holds seconds, minutes, hours, weekday, day of month, month and a two-digit year as binary counters, and advances them by one second on each pulse of a one-second strobe, provided the oscillator-select field holds the running code. The host-visible time bytes are separate registers. They are refreshed from the counters in either BCD or plain binary, and with hours in 12-hour or 24-hour form.

Each advance is an update cycle in two phases. On the one-second strobe the counters step and the update-in-progress flag rises. On the next delay strobe the visible bytes are rewritten, the alarm and update-ended conditions are evaluated into interrupt flags, and the in-progress flag drops. While the set-mode input is high, the host can write the visible bytes freely and no refresh touches them. A time write outside set mode, or the end of set mode, decodes the seven visible bytes back into the counters.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the visible bytes read seconds 00, minutes 00, hours 00, weekday 00, day 01, month 01, year 00; `uip`, `irq` and `int_flags` are all zero.
- R2: A `sec_tick` advances the counters and starts an update only when `osc_sel` is 3'b010; with any other code the second is dropped, `uip` stays low and no later update counts it.
- R3: Seconds wrap from 59 to 0 into minutes, minutes from 59 to 0 into hours, hours from 23 to 0 into a new day; weekday steps 0..6 and wraps to 0.
- R4: Month lengths are 31,28,31,30,31,30,31,31,30,31,30,31; February has 29 days when the two-digit year is a multiple of 4 (years 2000 to 2099). The day returns to 1 past the month length, December rolls to January with the year stepping, and year 99 wraps to 00. Months read as 1..12.
- R5: With `bin_mode` high all time bytes are plain binary; with it low each is two BCD digits, tens in bits 7:4.
- R6: With `h24_mode` low the hours byte holds the hour modulo 12 and bit 7 is set for hours 12 to 23; with it high the hours byte holds 0..23 and bit 7 is clear.
- R7: `uip` rises in the cycle after an accepted `sec_tick` unless `set_mode` is high, falls in the cycle after the following `dly_tick`, and is forced low in the cycle after `set_mode` rises. The visible bytes do not change between `sec_tick` and `dly_tick`.
- R8: While `set_mode` is high, update cycles leave the visible bytes unchanged; only host writes alter them.
- R9: A write (`wr_en`, `wr_sel` 0..6 = seconds, minutes, hours, weekday, day, month, year) stores `wr_data` in the visible byte at once; when `set_mode` is low, or when `set_mode` later falls, the counters are reloaded from the visible bytes, so the next update continues from the written time. `wr_sel` 7 is ignored.
- R10: With `alarm_en` high, at the end of an update, if each of the three alarm bytes either has bits 7:6 both set or equals the seconds, minutes or hours counter in the selected data and hour format, `int_flags` bits 7 and 5 are set.
- R11: With `upd_int_en` high, every completed update sets `int_flags` bits 7 and 4; the flags change only at the end of an update, never at its start.
- R12: Flags stay set until a `flag_clr` pulse clears `int_flags` to zero; `irq` equals `int_flags` bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-second strobe, starts an update |
| dly_tick | input | 1 | Delay strobe, ends an update |
| osc_sel | input | 3 | Oscillator select; 3'b010 lets time run |
| set_mode | input | 1 | Freeze visible bytes for host setting |
| bin_mode | input | 1 | 1 = binary, 0 = BCD |
| h24_mode | input | 1 | 1 = 24-hour, 0 = 12-hour |
| alarm_en | input | 1 | Enable alarm flag |
| upd_int_en | input | 1 | Enable update-ended flag |
| alarm_sec | input | 8 | Seconds alarm byte |
| alarm_min | input | 8 | Minutes alarm byte |
| alarm_hr | input | 8 | Hours alarm byte |
| wr_en | input | 1 | Time byte write strobe |
| wr_sel | input | 3 | Time byte select |
| wr_data | input | 8 | Time byte write data |
| flag_clr | input | 1 | Clear interrupt flags |
| t_sec | output | 8 | Visible seconds |
| t_min | output | 8 | Visible minutes |
| t_hr | output | 8 | Visible hours |
| t_wday | output | 8 | Visible weekday |
| t_mday | output | 8 | Visible day of month |
| t_mon | output | 8 | Visible month |
| t_year | output | 8 | Visible year |
| uip | output | 1 | Update in progress |
| int_flags | output | 8 | Interrupt flags (bit 7 any, bit 5 alarm, bit 4 update) |
| irq | output | 1 | Interrupt request |

## Verification
The hardest states to reach are the rare calendar carries: a year end, a leap and a non-leap February, a 30-day month, and the 11 to 12 crossings of the 12-hour clock, which from a reset value would take millions of seconds of strobes. The bench gets there by entering set mode, writing an arbitrary time just before the carry in the chosen format, leaving set mode so the counters reload, and then running a single update. The skipped-second case and the interplay of set mode with a pending update are driven as directed sequences that check the visible bytes both between and after the two strobes.

// File: rtl/rtc_calendar.sv
module rtc_calendar (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sec_tick,
  input  logic       dly_tick,
  input  logic [2:0] osc_sel,
  input  logic       set_mode,
  input  logic       bin_mode,
  input  logic       h24_mode,
  input  logic       alarm_en,
  input  logic       upd_int_en,
  input  logic [7:0] alarm_sec,
  input  logic [7:0] alarm_min,
  input  logic [7:0] alarm_hr,
  input  logic       wr_en,
  input  logic [2:0] wr_sel,
  input  logic [7:0] wr_data,
  input  logic       flag_clr,
  output logic [7:0] t_sec,
  output logic [7:0] t_min,
  output logic [7:0] t_hr,
  output logic [7:0] t_wday,
  output logic [7:0] t_mday,
  output logic [7:0] t_mon,
  output logic [7:0] t_year,
  output logic       uip,
  output logic [7:0] int_flags,
  output logic       irq
);

  localparam logic [2:0] OSC_RUN  = 3'b010;
  localparam logic [1:0] WILDCARD = 2'b11;

  function automatic logic [7:0] to_bcd(input logic [7:0] v);
    logic [7:0] tens, ones;
    tens = v / 8'd10;
    ones = v - tens * 8'd10;
    return {tens[3:0], ones[3:0]};
  endfunction

  function automatic logic [7:0] from_bcd(input logic [7:0] v);
    return {4'd0, v[7:4]} * 8'd10 + {4'd0, v[3:0]};
  endfunction

  logic [7:0] c_sec, c_min, c_hr, c_wday, c_mday, c_mon, c_yr;
  logic [7:0] n_sec, n_min, n_hr, n_wday, n_mday, n_mon, n_yr;
  logic [7:0] dim;
  logic       pend, set_q, reload_q, alarm_f, upd_f;
  logic       osc_ok, start_upd, end_upd, alarm_hit;

  assign osc_ok    = (osc_sel == OSC_RUN);
  assign start_upd = sec_tick && !pend && osc_ok;
  assign end_upd   = dly_tick && pend;

  // month length for the current counters
  always_comb begin
    case (c_mon)
      8'd1:                    dim = (c_yr[1:0] == 2'b00) ? 8'd29 : 8'd28;
      8'd3, 8'd5, 8'd8, 8'd10: dim = 8'd30;
      default:                 dim = 8'd31;
    endcase
  end

  // next-second arithmetic in binary
  always_comb begin
    n_sec  = c_sec + 8'd1;
    n_min  = c_min;
    n_hr   = c_hr;
    n_wday = c_wday;
    n_mday = c_mday;
    n_mon  = c_mon;
    n_yr   = c_yr;
    if (n_sec >= 8'd60) begin
      n_sec = 8'd0;
      n_min = c_min + 8'd1;
      if (n_min >= 8'd60) begin
        n_min = 8'd0;
        n_hr  = c_hr + 8'd1;
        if (n_hr >= 8'd24) begin
          n_hr   = 8'd0;
          n_wday = (c_wday + 8'd1 >= 8'd7) ? 8'd0 : c_wday + 8'd1;
          n_mday = c_mday + 8'd1;
          if (n_mday == 8'd0) begin
            n_mday = 8'd1;
          end else if (n_mday > dim) begin
            n_mday = 8'd1;
            n_mon  = c_mon + 8'd1;
            if (n_mon >= 8'd12) begin
              n_mon = 8'd0;
              n_yr  = (c_yr >= 8'd99) ? 8'd0 : c_yr + 8'd1;
            end
          end
        end
      end
    end
  end

  // encoding of the counters into the selected visible format
  logic [7:0] e_sec, e_min, e_hr, e_wday, e_mday, e_mon, e_yr, hr12;
  assign hr12   = (c_hr >= 8'd12) ? c_hr - 8'd12 : c_hr;
  assign e_sec  = bin_mode ? c_sec  : to_bcd(c_sec);
  assign e_min  = bin_mode ? c_min  : to_bcd(c_min);
  assign e_wday = bin_mode ? c_wday : to_bcd(c_wday);
  assign e_mday = bin_mode ? c_mday : to_bcd(c_mday);
  assign e_mon  = bin_mode ? c_mon + 8'd1 : to_bcd(c_mon + 8'd1);
  assign e_yr   = bin_mode ? c_yr   : to_bcd(c_yr);
  always_comb begin
    if (h24_mode) e_hr = bin_mode ? c_hr : to_bcd(c_hr);
    else          e_hr = (bin_mode ? hr12 : to_bcd(hr12)) | ((c_hr >= 8'd12) ? 8'h80 : 8'h00);
  end

  // decoding of the visible bytes back into counters
  logic [7:0] d_sec, d_min, d_hr, d_hraw, d_wday, d_mday, d_mon, d_yr;
  assign d_sec  = bin_mode ? t_sec  : from_bcd(t_sec);
  assign d_min  = bin_mode ? t_min  : from_bcd(t_min);
  assign d_hraw = bin_mode ? (t_hr & 8'h7f) : from_bcd(t_hr & 8'h7f);
  assign d_hr   = (!h24_mode && t_hr[7]) ? d_hraw + 8'd12 : d_hraw;
  assign d_wday = bin_mode ? t_wday : from_bcd(t_wday);
  assign d_mday = bin_mode ? t_mday : from_bcd(t_mday);
  assign d_mon  = (bin_mode ? t_mon : from_bcd(t_mon)) - 8'd1;
  assign d_yr   = bin_mode ? t_year : from_bcd(t_year);

  assign alarm_hit = (alarm_sec[7:6] == WILDCARD || alarm_sec == e_sec) &&
                     (alarm_min[7:6] == WILDCARD || alarm_min == e_min) &&
                     (alarm_hr[7:6]  == WILDCARD || alarm_hr  == e_hr);

  // counters
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_sec <= 8'd0; c_min <= 8'd0; c_hr <= 8'd0; c_wday <= 8'd0;
      c_mday <= 8'd1; c_mon <= 8'd0; c_yr <= 8'd0;
    end else if (reload_q) begin
      c_sec <= d_sec; c_min <= d_min; c_hr <= d_hr; c_wday <= d_wday;
      c_mday <= d_mday; c_mon <= d_mon; c_yr <= d_yr;
    end else if (start_upd) begin
      c_sec <= n_sec; c_min <= n_min; c_hr <= n_hr; c_wday <= n_wday;
      c_mday <= n_mday; c_mon <= n_mon; c_yr <= n_yr;
    end
  end

  // update sequencing and flags
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0; uip <= 1'b0; set_q <= 1'b0; reload_q <= 1'b0;
      alarm_f <= 1'b0; upd_f <= 1'b0;
    end else begin
      set_q    <= set_mode;
      reload_q <= (wr_en && wr_sel != 3'd7 && !set_mode) || (set_q && !set_mode);
      if (start_upd) begin
        pend <= 1'b1;
        uip  <= !set_mode;
      end else if (end_upd) begin
        pend <= 1'b0;
        uip  <= 1'b0;
      end
      if (set_mode && !set_q) uip <= 1'b0;
      if (flag_clr) begin
        alarm_f <= 1'b0;
        upd_f   <= 1'b0;
      end
      if (end_upd && alarm_en && alarm_hit) alarm_f <= 1'b1;
      if (end_upd && upd_int_en)            upd_f   <= 1'b1;
    end
  end

  // visible bytes
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t_sec <= 8'h00; t_min <= 8'h00; t_hr <= 8'h00; t_wday <= 8'h00;
      t_mday <= 8'h01; t_mon <= 8'h01; t_year <= 8'h00;
    end else begin
      if (end_upd && !set_mode) begin
        t_sec <= e_sec; t_min <= e_min; t_hr <= e_hr; t_wday <= e_wday;
        t_mday <= e_mday; t_mon <= e_mon; t_year <= e_yr;
      end
      if (wr_en) begin
        case (wr_sel)
          3'd0: t_sec  <= wr_data;
          3'd1: t_min  <= wr_data;
          3'd2: t_hr   <= wr_data;
          3'd3: t_wday <= wr_data;
          3'd4: t_mday <= wr_data;
          3'd5: t_mon  <= wr_data;
          3'd6: t_year <= wr_data;
          default: ;
        endcase
      end
    end
  end

  assign irq       = alarm_f | upd_f;
  assign int_flags = {irq, 1'b0, alarm_f, upd_f, 4'b0000};

  assert_uip_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uip) |-> ($past(sec_tick) && $past(osc_sel) == OSC_RUN && !$past(set_mode)));

  assert_uip_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(uip) |-> $past(dly_tick || set_mode));

  assert_frozen_in_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (set_mode && !wr_en) |=> ($stable(t_sec) && $stable(t_hr) && $stable(t_mday)));

  assert_alarm_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_flags[5]) |-> $past(dly_tick && alarm_en));

  assert_update_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_flags[4]) |-> $past(dly_tick && upd_int_en));

  assert_flag_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !dly_tick) |=> (int_flags == 8'h00));

endmodule

// File: tb/tb_rtc_calendar.sv
module tb_rtc_calendar;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sec_tick = 0, dly_tick = 0, set_mode = 0, bin_mode = 0, h24_mode = 1;
  logic alarm_en = 0, upd_int_en = 0, wr_en = 0, flag_clr = 0;
  logic [2:0] osc_sel = 3'b010, wr_sel = 3'd0;
  logic [7:0] alarm_sec = 0, alarm_min = 0, alarm_hr = 0, wr_data = 0;
  logic [7:0] t_sec, t_min, t_hr, t_wday, t_mday, t_mon, t_year, int_flags;
  logic uip, irq;
  int nchk = 0, nfail = 0;

  always #10 clk = ~clk;

  rtc_calendar dut (.*);

  // {bin, h24, loaded bytes sec..year, expected bytes after one update}
  localparam logic [113:0] VEC [0:12] = '{
    {1'b0, 1'b1, 56'h59_59_23_06_31_12_99, 56'h00_00_00_00_01_01_00},
    {1'b0, 1'b1, 56'h59_59_23_03_28_02_24, 56'h00_00_00_04_29_02_24},
    {1'b0, 1'b1, 56'h59_59_23_02_28_02_23, 56'h00_00_00_03_01_03_23},
    {1'b1, 1'b1, 56'h1E_14_0A_01_0F_06_05, 56'h1F_14_0A_01_0F_06_05},
    {1'b1, 1'b1, 56'h3B_3B_17_00_1E_04_0A, 56'h00_00_00_01_01_05_0A},
    {1'b0, 1'b0, 56'h59_59_11_02_10_03_21, 56'h00_00_80_02_10_03_21},
    {1'b0, 1'b0, 56'h59_59_91_05_10_03_21, 56'h00_00_00_06_11_03_21},
    {1'b1, 1'b0, 56'h09_00_85_03_01_01_01, 56'h0A_00_85_03_01_01_01},
    {1'b0, 1'b1, 56'h59_59_09_01_05_07_30, 56'h00_00_10_01_05_07_30},
    {1'b0, 1'b1, 56'h59_59_23_01_28_02_00, 56'h00_00_00_02_29_02_00},
    {1'b0, 1'b1, 56'h59_59_23_04_29_02_24, 56'h00_00_00_05_01_03_24},
    {1'b0, 1'b1, 56'h56_34_12_03_15_08_19, 56'h57_34_12_03_15_08_19},
    {1'b0, 1'b0, 56'h59_59_80_00_01_01_22, 56'h00_00_81_00_01_01_22}
  };

  function automatic logic [55:0] now_time();
    return {t_sec, t_min, t_hr, t_wday, t_mday, t_mon, t_year};
  endfunction

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic pulse_sec();
    @(negedge clk) sec_tick = 1'b1;
    @(negedge clk) sec_tick = 1'b0;
  endtask

  task automatic pulse_dly();
    @(negedge clk) dly_tick = 1'b1;
    @(negedge clk) dly_tick = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk) flag_clr = 1'b1;
    @(negedge clk) flag_clr = 1'b0;
  endtask

  task automatic run_update();
    pulse_sec();
    repeat (2) @(negedge clk);
    pulse_dly();
    @(negedge clk);
  endtask

  task automatic write_byte(input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk) begin wr_en = 1'b1; wr_sel = sel; wr_data = d; end
    @(negedge clk) wr_en = 1'b0;
  endtask

  task automatic load_time(input logic b, input logic h, input logic [55:0] t);
    @(negedge clk) begin set_mode = 1'b1; bin_mode = b; h24_mode = h; end
    for (int i = 0; i < 7; i++) write_byte(3'(i), t[55 - 8*i -: 8]);
    @(negedge clk) set_mode = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 time", 64'(now_time()), 64'h00_00_00_00_01_01_00);
    check("R1 flags", {54'd0, uip, irq, int_flags}, 64'd0);

    // R3 R4 R5 R6 R9: calendar carries in each format
    for (int v = 0; v < 13; v++) begin
      load_time(VEC[v][113], VEC[v][112], VEC[v][111:56]);
      run_update();
      check("R3 R4 R5 R6 R9 vector", 64'(now_time()), 64'(VEC[v][55:0]));
    end

    // R2: invalid oscillator code drops the second
    load_time(1'b0, 1'b1, 56'h56_34_12_03_15_08_19);
    osc_sel = 3'b000;
    pulse_sec();
    check("R2 no uip", {63'd0, uip}, 64'd0);
    pulse_dly();
    check("R2 time held", 64'(t_sec), 64'h56);
    osc_sel = 3'b010;
    run_update();
    check("R2 skipped second", 64'(t_sec), 64'h57);

    // R7: two-phase update
    pulse_sec();
    check("R7 uip set", {63'd0, uip}, 64'd1);
    check("R7 no early copy", 64'(t_sec), 64'h57);
    pulse_dly();
    check("R7 uip clear", {63'd0, uip}, 64'd0);
    check("R7 copy-out", 64'(t_sec), 64'h58);

    // R7 R8: entering set mode mid-update
    pulse_sec();
    @(negedge clk) set_mode = 1'b1;
    @(negedge clk);
    check("R7 set clears uip", {63'd0, uip}, 64'd0);
    pulse_dly();
    check("R8 frozen", 64'(t_sec), 64'h58);
    run_update();
    check("R8 frozen again", {63'd0, uip, t_sec}, 64'h58);
    write_byte(3'd0, 8'h10);
    check("R9 write in set", 64'(t_sec), 64'h10);
    @(negedge clk) set_mode = 1'b0;
    repeat (3) @(negedge clk);
    run_update();
    check("R9 reload on leaving set", 64'(t_sec), 64'h11);

    // R9: direct write outside set mode
    write_byte(3'd0, 8'h40);
    check("R9 direct write", 64'(t_sec), 64'h40);
    repeat (2) @(negedge clk);
    write_byte(3'd7, 8'h33);
    check("R9 sel 7 ignored", 64'(now_time()), 64'h40_34_12_03_15_08_19);
    run_update();
    check("R9 reload outside set", 64'(t_sec), 64'h41);

    // R10 R12: alarm match, wildcards, clear
    alarm_en = 1'b1; alarm_sec = 8'h42; alarm_min = 8'h34; alarm_hr = 8'h12;
    pulse_sec();
    check("R11 no flag at start", 64'(int_flags), 64'h00);
    repeat (2) @(negedge clk);
    pulse_dly();
    check("R10 exact match", {55'd0, irq, int_flags}, 64'h1A0);
    pulse_clr();
    check("R12 clear", {55'd0, irq, int_flags}, 64'h000);
    alarm_sec = 8'hC0; alarm_min = 8'hFF;
    run_update();
    check("R10 wildcard match", 64'(int_flags), 64'hA0);
    pulse_clr();
    alarm_hr = 8'h13;
    run_update();
    check("R10 mismatch", 64'(int_flags), 64'h00);
    alarm_hr = 8'hC0;
    alarm_en = 1'b0;
    run_update();
    check("R10 disabled", 64'(int_flags), 64'h00);

    // R11: update-ended flag, alone and with alarm
    upd_int_en = 1'b1;
    run_update();
    check("R11 update flag", {55'd0, irq, int_flags}, 64'h190);
    pulse_clr();
    alarm_en = 1'b1;
    run_update();
    check("R10 R11 both", 64'(int_flags), 64'hB0);
    repeat (3) @(negedge clk);
    check("R12 flags held", 64'(int_flags), 64'hB0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule